// File: doc/BRIEF.md
# I2S to Simultaneous-Mode DAC Formatter

This block takes a standard I2S stream and reformats it for a 16-bit multibit current-steering DAC that is fed in simultaneous mode. The input frame carries 64 bit cells per sample: a left slot of 32 cells while word select is low, then a right slot of 32 cells while it is high. The output is a free-running bit clock at a quarter of the input bit rate, which gives 16 cells per sample. Two data lanes, one per channel, shift out together, and a latch-enable pulse moves each finished pair of words into the converter. At a 192 kHz sample rate the output bit clock is therefore 3.072 MHz.

The whole block runs on one system clock. A strobe, `bit_en`, marks each input bit cell and stands in for the rising edge of the input bit clock. Each channel has an elastic 64-bit FIFO. Only the 16 wanted bits of a slot are written into it, at the fast rate, and it is read at the slow rate. The left word is held back until its right partner is complete, so both leave the block aligned, one sample late. The most significant bit of every word is inverted on its way into the FIFO.

An overflow or an underflow sets a sticky error flag. Both FIFOs are then flushed, and capture restarts at the next left-word boundary.

Top module: `i2s_sim_formatter`

## Requirements
- R1: `obck_o` is 0 out of reset. It rises after every second `bit_en` strobe and falls after every fourth, so it runs at one quarter of the input bit rate with 50 % duty and never stops, whatever the data.
- R2: A change of `ws_i` between two strobes marks a slot boundary. The strobe that sees the change is a delay cell. The next 16 strobes carry the word, MSB first. `ws_i` low selects the left FIFO and high selects the right FIFO. The strobe at the boundary and slot cells 17 onward are not written.
- R3: The first captured bit of each word (the MSB) is stored inverted. The other 15 bits are stored unchanged.
- R4: `dl_o` and `dr_o` change only when `obck_o` falls, and they are valid at its rising edge. Each lane carries the left and right word of the same frame in the same 16 output cells.
- R5: Reading starts on an output cell boundary, and only once both FIFOs hold at least 16 bits. Until then `dl_o`, `dr_o` and `le_o` stay 0.
- R6: `le_o` rises together with the `obck_o` rising edge that samples the 16th bit of a word. It falls at the next `obck_o` rising edge, so it is high for exactly one output clock period.
- R7: Each channel FIFO holds 64 bits. Writing a bit into a full FIFO is an overflow.
- R8: An overflow, or a read while running from an empty FIFO (underflow), sets `err_o`. `err_o` clears only on reset. The same strobe flushes both FIFOs and stops reading. Output resumes after both FIFOs again hold a full word.
- R9: After reset or after an error, nothing is written until the MSB cell of a left slot. A right slot that arrives first is discarded, so the left and right words pair up by frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | One-cycle strobe per input bit cell (input bit clock rising edge) |
| ws_i | input | 1 | I2S word select, sampled on `bit_en`; low = left |
| sd_i | input | 1 | I2S serial data, sampled on `bit_en` |
| obck_o | output | 1 | Continuous output bit clock, input bit rate / 4 |
| dl_o | output | 1 | Left-channel serial data, MSB first |
| dr_o | output | 1 | Right-channel serial data, MSB first |
| le_o | output | 1 | Latch-enable pulse, one output clock period per word |
| err_o | output | 1 | Sticky FIFO overflow or underflow flag |

## Verification
Most internal faults in this block show up at the ports within one output word. A wrong slot counter or a wrong MSB inversion gives a decoded word that differs from the word that was sent. A divider or cell-counter fault moves `le_o` or an `obck_o` edge by at least one input strobe. FIFO pointer or fill-level faults are slower to appear: they show as wrong bits, or as `err_o` rising on a different strobe than the limit of 64 bits predicts. The bench therefore compares every clock cycle against a queue-based model, and it also decodes each latched word pair at the ports.

// File: rtl/i2s_sim_formatter.sv
module i2s_sim_formatter #(
  parameter int WORD  = 16,
  parameter int DEPTH = 64,
  parameter int SLOT  = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic ws_i,
  input  logic sd_i,
  output logic obck_o,
  output logic dl_o,
  output logic dr_o,
  output logic le_o,
  output logic err_o
);
  localparam int AW  = $clog2(DEPTH);
  localparam int PW  = $clog2(SLOT);
  localparam int OW  = $clog2(WORD);
  localparam logic [AW:0]   FULL   = (AW+1)'(DEPTH);
  localparam logic [AW:0]   WFILL  = (AW+1)'(WORD);
  localparam logic [PW-1:0] LASTIN = PW'(WORD);
  localparam logic [OW-1:0] LASTOUT = OW'(WORD-1);

  logic          ws_q, armed, running;
  logic [PW-1:0] pos, pos_n;
  logic [1:0]    div;
  logic [OW-1:0] obit;
  logic [DEPTH-1:0] mem [2];
  logic [AW-1:0] wp [2];
  logic [AW-1:0] rp [2];
  logic [AW:0]   cnt [2];

  logic arm_n, wr, wbit, slot_end, have_word, ovf, udf, fault, pop;
  logic [1:0] wrv;

  assign pos_n     = (ws_i != ws_q) ? '0 : ((pos == '1) ? pos : pos + 1'b1);
  assign arm_n     = armed || (!ws_i && pos_n == PW'(1));
  assign wr        = arm_n && pos_n != '0 && pos_n <= LASTIN;
  assign wbit      = sd_i ^ (pos_n == PW'(1));
  assign wrv       = {wr && ws_i, wr && !ws_i};
  assign slot_end  = div == 2'd3;
  assign have_word = cnt[0] >= WFILL && cnt[1] >= WFILL;
  assign ovf       = wr && cnt[ws_i] == FULL;
  assign udf       = slot_end && running && (cnt[0] == '0 || cnt[1] == '0);
  assign fault     = ovf || udf;
  assign pop       = slot_end && (running ? !udf : have_word);
  assign obck_o    = div[1];

  always_ff @(posedge clk) begin
    if (bit_en && !fault && wr) mem[ws_i][wp[ws_i]] <= wbit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ws_q <= 1'b0; pos <= '1; div <= '0; obit <= '0;
      armed <= 1'b0; running <= 1'b0;
      dl_o <= 1'b0; dr_o <= 1'b0; le_o <= 1'b0; err_o <= 1'b0;
      for (int ch = 0; ch < 2; ch++) begin
        wp[ch] <= '0; rp[ch] <= '0; cnt[ch] <= '0;
      end
    end else if (bit_en) begin
      ws_q <= ws_i;
      pos  <= pos_n;
      div  <= div + 2'd1;
      if (fault) begin
        err_o <= 1'b1; running <= 1'b0; armed <= 1'b0; obit <= '0;
        for (int ch = 0; ch < 2; ch++) begin
          wp[ch] <= '0; rp[ch] <= '0; cnt[ch] <= '0;
        end
      end else begin
        armed <= arm_n;
        if (pop) begin
          dl_o    <= mem[0][rp[0]];
          dr_o    <= mem[1][rp[1]];
          running <= 1'b1;
          obit    <= (!running || obit == LASTOUT) ? '0 : obit + 1'b1;
        end
        if (div == 2'd1 && running && obit == LASTOUT) le_o <= 1'b1;
        else if (div == 2'd1 && obit == '0)            le_o <= 1'b0;
        for (int ch = 0; ch < 2; ch++) begin
          if (wrv[ch]) wp[ch] <= wp[ch] + 1'b1;
          if (pop)     rp[ch] <= rp[ch] + 1'b1;
          cnt[ch] <= cnt[ch] + (AW+1)'(wrv[ch]) - (AW+1)'(pop);
        end
      end
    end
  end

  assert_obck_pace_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(bit_en) |-> $stable(obck_o));

  assert_lane_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dl_o) || !$stable(dr_o)) |-> $fell(obck_o));

  assert_start_full_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) |-> ($past(cnt[0]) >= WFILL && $past(cnt[1]) >= WFILL));

  assert_le_on_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(le_o) || $fell(le_o)) |-> $rose(obck_o));

  assert_no_overfill_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt[0] <= FULL && cnt[1] <= FULL);

  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(err_o) |-> err_o);
endmodule

// File: tb/sim_i2s_sim_formatter.sv
module sim_i2s_sim_formatter;
  logic clk = 1'b0, rst_n = 1'b0, bit_en = 1'b0, ws_i = 1'b0, sd_i = 1'b0;
  logic obck_o, dl_o, dr_o, le_o, err_o;

  i2s_sim_formatter u0 (.clk(clk), .rst_n(rst_n), .bit_en(bit_en), .ws_i(ws_i), .sd_i(sd_i),
    .obck_o(obck_o), .dl_o(dl_o), .dr_o(dr_o), .le_o(le_o), .err_o(err_o));

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit cmp_on = 0, dec_on = 0;
  int le_count = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  // behavioural reference model
  bit ql[$], qr[$];
  int m_pos, m_div, m_obit;
  bit m_wsq, m_armed, m_run, m_dl, m_dr, m_le, m_err;

  always @(posedge clk) begin
    if (!rst_n) begin
      ql.delete(); qr.delete();
      m_pos = 31; m_div = 0; m_obit = 0; m_wsq = 0; m_armed = 0; m_run = 0;
      m_dl = 0; m_dr = 0; m_le = 0; m_err = 0;
    end else if (bit_en) begin
      int npos;
      bit arm, wr, bv, fault, pop;
      npos  = (ws_i != m_wsq) ? 0 : (m_pos == 31 ? 31 : m_pos + 1);
      arm   = m_armed || (!ws_i && npos == 1);
      wr    = arm && npos >= 1 && npos <= 16;
      bv    = (npos == 1) ? !sd_i : sd_i;
      fault = 0; pop = 0;
      if (wr && (ws_i ? qr.size() : ql.size()) == 64) fault = 1;
      if (m_div == 3) begin
        if (m_run) begin
          if (ql.size() == 0 || qr.size() == 0) fault = 1; else pop = 1;
        end else if (ql.size() >= 16 && qr.size() >= 16) pop = 1;
      end
      if (fault) begin
        ql.delete(); qr.delete();
        m_run = 0; m_armed = 0; m_err = 1; m_obit = 0;
      end else begin
        if (m_div == 1) begin
          if (m_run && m_obit == 15) m_le = 1;
          else if (m_obit == 0) m_le = 0;
        end
        if (pop) begin
          m_dl = ql.pop_front(); m_dr = qr.pop_front();
          m_obit = m_run ? (m_obit + 1) % 16 : 0;
          m_run = 1;
        end
        if (wr) begin
          if (ws_i) qr.push_back(bv); else ql.push_back(bv);
        end
        m_armed = arm;
      end
      m_wsq = ws_i; m_pos = npos; m_div = (m_div + 1) % 4;
    end
  end

  // per-cycle comparison and port-level word decode
  logic [15:0] el[$], er[$];
  logic [15:0] sl = 0, sr = 0;
  bit p_obck = 0, p_le = 0;

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      bit ob;
      ob = (m_div >= 2);
      check(obck_o == ob, "R1 obck", obck_o, ob);
      check(dl_o == m_dl, "R4 dl", dl_o, m_dl);
      check(dr_o == m_dr, "R4 dr", dr_o, m_dr);
      check(le_o == m_le, "R6 le", le_o, m_le);
      check(err_o == m_err, "R8 err", err_o, m_err);
      if (!p_obck && obck_o) begin
        sl = {sl[14:0], dl_o};
        sr = {sr[14:0], dr_o};
      end
      if (!p_le && le_o) begin
        le_count++;
        if (dec_on) begin
          if (el.size() == 0) check(0, "R4 unexpected word", sl, 0);
          else begin
            logic [15:0] xl, xr;
            xl = el.pop_front(); xr = er.pop_front();
            check(sl == xl, "R2 R3 left word", sl, xl);
            check(sr == xr, "R2 R3 right word", sr, xr);
          end
        end
      end
      p_obck = obck_o; p_le = le_o;
    end
  end

  task automatic send_bit(input bit w, input bit d, input int gap);
    @(negedge clk); bit_en = 1; ws_i = w; sd_i = d;
    @(negedge clk); bit_en = 0;
    repeat (gap - 2) @(negedge clk);
  endtask

  task automatic send_frame(input logic [15:0] l, input logic [15:0] r, input int gap);
    if (dec_on) begin
      el.push_back(l ^ 16'h8000);
      er.push_back(r ^ 16'h8000);
    end
    for (int i = 0; i < 64; i++) begin
      int p;
      bit w, d;
      p = i % 32;
      w = (i >= 32);
      if (p >= 1 && p <= 16) d = w ? r[16 - p] : l[16 - p];
      else d = 1'($urandom);
      send_bit(w, d, gap);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000 - 50000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog: got %0d expected %0d", 1, 0);
    finish_run();
  end

  initial begin
    logic [15:0] pat [6];
    pat[0] = 16'h0000; pat[1] = 16'hFFFF; pat[2] = 16'h8000;
    pat[3] = 16'h7FFF; pat[4] = 16'hA5A5; pat[5] = 16'h0001;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 R5: reset state
    check(obck_o == 0, "R1 reset obck", obck_o, 0);
    check(dl_o == 0 && dr_o == 0, "R5 reset lanes", {dl_o, dr_o}, 0);
    check(le_o == 0, "R6 reset le", le_o, 0);
    check(err_o == 0, "R8 reset err", err_o, 0);
    cmp_on = 1;
    // R9: a stray right slot before any left slot is dropped
    for (int i = 0; i < 10; i++) send_bit(1, 1'($urandom), 2);
    dec_on = 1;
    for (int f = 0; f < 30; f++) begin
      logic [15:0] l, r;
      l = (f < 6) ? pat[f] : 16'($urandom);
      r = (f < 6) ? pat[5 - f] : 16'($urandom);
      send_frame(l, r, (f % 3 == 2) ? 3 : 2);
    end
    // drain with word select held high: stored words come out, then underflow
    for (int i = 0; i < 200; i++) send_bit(1, 1'($urandom), 2);
    check(el.size() == 0, "R4 all words delivered", el.size(), 0);
    check(err_o == 1, "R8 underflow flag", err_o, 1);
    // R8 R9: resume on the next left MSB
    for (int f = 0; f < 10; f++) send_frame(16'($urandom), 16'($urandom), 2);
    for (int i = 0; i < 200; i++) send_bit(1, 1'($urandom), 2);
    check(el.size() == 0, "R8 words after resync", el.size(), 0);
    check(err_o == 1, "R8 flag stays set", err_o, 1);
    // R7: overflow with 17-cell slots
    dec_on = 0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(err_o == 0, "R8 cleared by reset", err_o, 0);
    for (int k = 0; k < 40; k++)
      for (int p = 0; p < 17; p++) send_bit(k % 2 == 1, 1'($urandom), 2);
    check(err_o == 1, "R7 overflow flag", err_o, 1);
    le_count = 0;
    for (int f = 0; f < 10; f++) send_frame(16'($urandom), 16'($urandom), 2);
    check(le_count > 0, "R8 output resumes", le_count, 1);
    check(err_o == 1, "R8 flag sticky after resume", err_o, 1);
    finish_run();
  end
endmodule